// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable, cycle-accurate model of a common-I/O SRAM that transfers every access as a burst of two words, one word per clock edge. It runs on a single fast clock at twice the command rate. Each command period is two fast cycles. The first fast edge stands for the rising edge of the true clock (the "K edge") and the second stands for the rising edge of the complementary clock (the "K-bar edge"). The model is meant to sit behind a memory controller under test in simulation or emulation. It provides the exact data timing of the real memory without any analog or clock-recovery behaviour.

Commands are sampled only on K edges. Data phases are decoupled from commands. Write data arrives one command period after its address, on two consecutive fast edges, and each beat carries its own lane mask. Read data leaves 2.5 command periods after the command, starting on a K-bar edge. A drive-enable output replaces the tri-state pad, and it is high only while a read beat is on the bus. A command may be issued on every K edge. In-flight reads and writes are tracked in fast-cycle shift registers, so overlapping bursts complete on schedule.

The edge phase is held by a two-state machine. Its states are `PH_K`, meaning the next edge is a K edge, and `PH_KB`, meaning the next edge is a K-bar edge. It has two transitions: `PH_K -> PH_KB` and `PH_KB -> PH_K`, one on every fast edge. Reset forces `PH_K`.

Top module: `burst2_ddr_sram`

## Requirements
- R1: On a K edge, `cmd_start_n` low with `cmd_is_read` high starts a read, and `cmd_start_n` low with `cmd_is_read` low starts a write. `cmd_start_n` high is a no-operation. Command inputs are ignored on K-bar edges.
- R2: A burst at address A touches array word {A, 0} first and word {A, 1} second. The second beat never carries into the next burst address, including at the highest address.
- R3: For a write command on fast edge e, the first beat is captured into {A,0} on edge e+2, which is a K edge. The second beat is captured into {A,1} on edge e+3.
- R4: For a read command on fast edge e, word {A,0} is driven on edge e+5, which is a K-bar edge. Word {A,1} is driven on edge e+6.
- R5: `beat_lane_n` is active low and is sampled separately with each write beat, so the two beats of one burst may use different masks. A lane whose bit is high keeps its stored contents.
- R6: With the 18-bit word, `beat_lane_n[0]` covers bits [8:0] and `beat_lane_n[1]` covers bits [17:9]. With the 8-bit word, they cover bits [3:0] and [7:4]. When both bits are high, that beat writes nothing.
- R7: Reset puts the phase in `PH_K`, discards every in-flight beat, and holds `beat_drive` low.
- R8: `beat_drive` is high exactly on the fast cycles that follow a read-beat edge and is low on all other cycles.
- R9: Commands may be issued on consecutive K edges. Beats already in flight complete on their scheduled edges regardless of later commands or no-operations.
- R10: A read issued on the K edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per command period |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start_n | input | 1 | Active-low transaction start, sampled on K edges |
| cmd_is_read | input | 1 | High selects read, low selects write |
| cmd_addr | input | AW | Burst address |
| beat_lane_n | input | 2 | Per-beat active-low lane write selects |
| beat_wdata | input | DW (18 or 8) | Write data beat |
| beat_rdata | output | DW (18 or 8) | Read data beat |
| beat_drive | output | 1 | High while a read beat is driven |

## Verification
The checker watches the timing skeleton on every cycle. A write command must raise the array write enable two and three fast edges later, and a read command must produce drive on the next two beat cycles. A no-operation must leave the drive slot low. Drive may only rise in a cycle that ends on a K edge, and it may never appear without a read command six or seven samples back. Data content is visible only to the bench scenarios: lane masking per beat, the no-write mask, address wrap inside a burst, read-after-write forwarding, and the reset that drops in-flight reads.

// File: rtl/burst2_pkg.sv
package burst2_pkg;

    typedef enum logic [0:0] {
        PH_K  = 1'b0,
        PH_KB = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    // fast edges from command edge to first beat
    localparam int WR_LAT = 2;
    localparam int RD_LAT = 5;

endpackage

// File: rtl/burst2_phase_fsm.sv
module burst2_phase_fsm
    import burst2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    input  logic is_read,
    output logic k_edge,
    output cmd_e cmd
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_K;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_K:    state_d = PH_KB;
            PH_KB:   state_d = PH_K;
            default: state_d = PH_K;
        endcase
    end

    always_comb begin
        k_edge = 1'b0;
        cmd    = CMD_NOP;
        unique case (state_q)
            PH_K: begin
                k_edge = 1'b1;
                if (!start_n) cmd = is_read ? CMD_READ : CMD_WRITE;
            end
            PH_KB: begin
                k_edge = 1'b0;
                cmd    = CMD_NOP;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/burst2_delay.sv
module burst2_delay #(
    parameter int W = 4,
    parameter int N = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_v,
    input  logic [W-1:0]          in_p,
    output logic [N-1:0]          tap_v,
    output logic [N-1:0][W-1:0]   tap_p
);

    always_ff @(posedge clk) begin
        if (rst) tap_v <= '0;
        else     tap_v <= {tap_v[N-2:0], in_v};
    end

    always_ff @(posedge clk) begin
        tap_p <= {tap_p[N-2:0], in_p};
    end

endmodule

// File: rtl/burst2_array.sv
module burst2_array #(
    parameter int DW    = 18,
    parameter int LANES = 2,
    parameter int IW    = 5,
    localparam int LW    = DW / LANES,
    localparam int DEPTH = 1 << IW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] lane_n,
    input  logic             re,
    input  logic [IW-1:0]    ridx,
    output logic [DW-1:0]    q,
    output logic             oe
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] cur;
    logic [DW-1:0] merged;

    assign cur = mem[widx];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LW +: LW] = lane_n[l] ? cur[l*LW +: LW] : wdata[l*LW +: LW];
    end

    always_ff @(posedge clk) begin
        if (we && !(&lane_n)) mem[widx] <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            oe <= 1'b0;
        end else if (re) begin
            q  <= mem[ridx];
            oe <= 1'b1;
        end else begin
            q  <= '0;
            oe <= 1'b0;
        end
    end

endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
    import burst2_pkg::*;
#(
    parameter bit  WIDE  = 1'b1,
    parameter int  AW    = 4,
    localparam int DW    = WIDE ? 18 : 8,
    localparam int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start_n,
    input  logic             cmd_is_read,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [LANES-1:0] beat_lane_n,
    input  logic [DW-1:0]    beat_wdata,
    output logic [DW-1:0]    beat_rdata,
    output logic             beat_drive
);

    localparam int WR_T0 = WR_LAT - 1;
    localparam int RD_T0 = RD_LAT - 1;
    localparam int WR_N  = WR_T0 + 2;
    localparam int RD_N  = RD_T0 + 2;
    localparam int IW    = AW + 1;

    logic k_edge;
    cmd_e cmd;

    logic [WR_N-1:0]          wv;
    logic [WR_N-1:0][AW-1:0]  wa;
    logic [RD_N-1:0]          rv;
    logic [RD_N-1:0][AW-1:0]  ra;

    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          rd_en;
    logic [IW-1:0] rd_idx;

    burst2_phase_fsm u_phase (
        .clk     (clk),
        .rst     (rst),
        .start_n (cmd_start_n),
        .is_read (cmd_is_read),
        .k_edge  (k_edge),
        .cmd     (cmd)
    );

    burst2_delay #(.W(AW), .N(WR_N)) u_wpipe (
        .clk   (clk),
        .rst   (rst),
        .in_v  (cmd == CMD_WRITE),
        .in_p  (cmd_addr),
        .tap_v (wv),
        .tap_p (wa)
    );

    burst2_delay #(.W(AW), .N(RD_N)) u_rpipe (
        .clk   (clk),
        .rst   (rst),
        .in_v  (cmd == CMD_READ),
        .in_p  (cmd_addr),
        .tap_v (rv),
        .tap_p (ra)
    );

    // beat 0 uses {A,0}; beat 1 uses {A,1}: only the low index bit changes
    always_comb begin
        wr_en  = wv[WR_T0] | wv[WR_T0+1];
        wr_idx = wv[WR_T0] ? {wa[WR_T0], 1'b0} : {wa[WR_T0+1], 1'b1};
        rd_en  = rv[RD_T0] | rv[RD_T0+1];
        rd_idx = rv[RD_T0] ? {ra[RD_T0], 1'b0} : {ra[RD_T0+1], 1'b1};
    end

    burst2_array #(.DW(DW), .LANES(LANES), .IW(IW)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .widx   (wr_idx),
        .wdata  (beat_wdata),
        .lane_n (beat_lane_n),
        .re     (rd_en),
        .ridx   (rd_idx),
        .q      (beat_rdata),
        .oe     (beat_drive)
    );

endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk (
    input logic clk,
    input logic rst,
    input logic k_edge,
    input logic cmd_start_n,
    input logic cmd_is_read,
    input logic wr_en,
    input logic beat_drive
);

    logic       rd_cmd;
    logic       wr_cmd;
    logic       nop_cmd;
    logic [2:0] since_rst;

    assign rd_cmd  = k_edge && !cmd_start_n && cmd_is_read;
    assign wr_cmd  = k_edge && !cmd_start_n && !cmd_is_read;
    assign nop_cmd = k_edge && cmd_start_n;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R3: write beats reach the array two and three edges after the command
    a_r3_write_beat0: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |-> ##2 wr_en);
    a_r3_write_beat1: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |-> ##3 wr_en);

    // R4: read beats are on the bus after edges e+5 and e+6
    a_r4_read_beat0: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |-> ##6 beat_drive);
    a_r4_read_beat1: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |-> ##7 beat_drive);

    // R1: a no-operation leaves its first read slot empty
    a_r1_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        nop_cmd |-> ##6 !beat_drive);

    // R8: a read burst starts on a K-bar edge
    a_r8_drive_starts_kbar: assert property (@(posedge clk) disable iff (rst)
        $rose(beat_drive) |-> k_edge);

    // R8: drive only from a read command
    a_r8_drive_has_cause: assert property (@(posedge clk) disable iff (rst)
        (beat_drive && since_rst == 3'd7) |-> ($past(rd_cmd, 6) || $past(rd_cmd, 7)));

    // R7: reset silences the bus
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> !beat_drive);

endmodule

bind burst2_ddr_sram burst2_sram_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .k_edge      (k_edge),
    .cmd_start_n (cmd_start_n),
    .cmd_is_read (cmd_is_read),
    .wr_en       (wr_en),
    .beat_drive  (beat_drive)
);

// File: tb/tb_burst2_ddr_sram.sv
module tb_burst2_ddr_sram;

    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int LW    = 9;
    localparam int NVEC  = 20;
    localparam int DEPTH = 1 << (AW + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_start_n;
    logic          cmd_is_read;
    logic [AW-1:0] cmd_addr;
    logic [1:0]    beat_lane_n;
    logic [DW-1:0] beat_wdata;
    logic [DW-1:0] beat_rdata;
    logic          beat_drive;

    always #10 clk = ~clk;

    burst2_ddr_sram #(.WIDE(1'b1), .AW(AW)) dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_start_n (cmd_start_n),
        .cmd_is_read (cmd_is_read),
        .cmd_addr    (cmd_addr),
        .beat_lane_n (beat_lane_n),
        .beat_wdata  (beat_wdata),
        .beat_rdata  (beat_rdata),
        .beat_drive  (beat_drive)
    );

    // entry: {op, addr, mask beat0, mask beat1}; op 0 = no-op, 1 = write, 2 = read
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd1, 4'd3,  2'b00, 2'b00},  // 0  full write a3
        {2'd2, 4'd3,  2'b00, 2'b00},  // 1  R10 read right after write
        {2'd1, 4'd5,  2'b00, 2'b00},  // 2
        {2'd1, 4'd6,  2'b00, 2'b00},  // 3  back-to-back writes
        {2'd2, 4'd5,  2'b00, 2'b00},  // 4  R9
        {2'd2, 4'd6,  2'b00, 2'b00},  // 5  R9 back-to-back reads
        {2'd0, 4'd9,  2'b00, 2'b00},  // 6
        {2'd1, 4'd3,  2'b01, 2'b10},  // 7  R5 different mask per beat
        {2'd2, 4'd3,  2'b00, 2'b00},  // 8
        {2'd1, 4'd5,  2'b11, 2'b11},  // 9  R6 both lanes off
        {2'd0, 4'd5,  2'b00, 2'b00},  // 10
        {2'd2, 4'd5,  2'b00, 2'b00},  // 11
        {2'd1, 4'd15, 2'b00, 2'b00},  // 12 R2 top address
        {2'd2, 4'd15, 2'b00, 2'b00},  // 13
        {2'd1, 4'd0,  2'b00, 2'b00},  // 14
        {2'd2, 4'd0,  2'b00, 2'b00},  // 15 R2 no carry from a15
        {2'd2, 4'd6,  2'b00, 2'b00},  // 16 R1 after K-bar junk commands
        {2'd0, 4'd0,  2'b00, 2'b00},
        {2'd0, 4'd0,  2'b00, 2'b00},
        {2'd0, 4'd0,  2'b00, 2'b00}
    };

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    bit            wv   [8];
    logic [AW:0]   widx [8];
    logic [DW-1:0] wd   [8];
    logic [1:0]    wm   [8];
    bit            rv   [8];
    logic [AW:0]   ridx [8];
    string         rtag [8];
    bit            exp_oe;
    logic [DW-1:0] exp_q;
    string         cur_tag;

    function automatic string tag_of(int i);
        case (i)
            1:       return "R10 R3";
            4, 5:    return "R9";
            8:       return "R5 R6";
            11:      return "R6";
            13, 15:  return "R2";
            16:      return "R1";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [DW-1:0] pat(int i, bit b);
        logic [5:0] t;
        t = i[5:0];
        return b ? {~t, 6'h15, t} : {t, 6'h2A, ~t};
    endfunction

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 8; k++) begin
            wv[k] = 1'b0;
            rv[k] = 1'b0;
        end
        exp_oe = 1'b0;
    endtask

    // called at a negedge: sets inputs for edge s, then checks after it
    task automatic step(int s, int vi, logic [1:0] op, logic [AW-1:0] a,
                        logic [1:0] m0, logic [1:0] m1);
        int k;
        k = s % 8;
        exp_oe = rv[k];
        if (rv[k]) begin
            exp_q   = ref_mem[ridx[k]];
            cur_tag = rtag[k];
        end
        rv[k] = 1'b0;
        if (wv[k]) begin
            for (int l = 0; l < 2; l++)
                if (!wm[k][l]) ref_mem[widx[k]][l*LW +: LW] = wd[k][l*LW +: LW];
            beat_wdata  = wd[k];
            beat_lane_n = wm[k];
            wv[k] = 1'b0;
        end else begin
            beat_wdata  = '1;
            beat_lane_n = 2'b00;
        end
        if (s % 2 == 0) begin
            cmd_start_n = (op == 2'd0);
            cmd_is_read = (op == 2'd2);
            cmd_addr    = a;
            if (op == 2'd1) begin
                wv[(s+2)%8] = 1'b1; widx[(s+2)%8] = {a, 1'b0};
                wd[(s+2)%8] = pat(vi, 1'b0); wm[(s+2)%8] = m0;
                wv[(s+3)%8] = 1'b1; widx[(s+3)%8] = {a, 1'b1};
                wd[(s+3)%8] = pat(vi, 1'b1); wm[(s+3)%8] = m1;
            end else if (op == 2'd2) begin
                rv[(s+5)%8] = 1'b1; ridx[(s+5)%8] = {a, 1'b0}; rtag[(s+5)%8] = tag_of(vi);
                rv[(s+6)%8] = 1'b1; ridx[(s+6)%8] = {a, 1'b1}; rtag[(s+6)%8] = tag_of(vi);
            end
        end else begin
            // R1: a read request on a K-bar edge must be ignored
            cmd_start_n = 1'b0;
            cmd_is_read = 1'b1;
            cmd_addr    = ~a;
        end
        @(negedge clk);
        check(beat_drive === exp_oe, "R8", "drive enable", {17'd0, beat_drive}, {17'd0, exp_oe});
        if (exp_oe)
            check(beat_rdata === exp_q, cur_tag, "read beat", beat_rdata, exp_q);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        cmd_start_n = 1'b1;
        cmd_is_read = 1'b0;
        cmd_addr    = '0;
        beat_lane_n = 2'b00;
        beat_wdata  = '0;
        cur_tag     = "R4";
        exp_q       = '0;
        clear_model();
        repeat (3) @(negedge clk);
        check(beat_drive === 1'b0, "R7", "drive in reset", {17'd0, beat_drive}, '0);
        rst = 1'b0;

        // table walk: one entry per K edge, then drain
        for (int s = 0; s < 2 * NVEC + 8; s++) begin
            int vi;
            vi = s / 2;
            if (vi < NVEC)
                step(s, vi, VEC[vi][9:8], VEC[vi][7:4], VEC[vi][3:2], VEC[vi][1:0]);
            else
                step(s, 0, 2'd0, '0, 2'b00, 2'b00);
        end

        // R7: reset while a read is in flight drops its beats
        clear_model();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 2'd2, 4'd6, 2'b00, 2'b00);
        step(1, 0, 2'd0, 4'd6, 2'b00, 2'b00);
        step(2, 0, 2'd0, 4'd6, 2'b00, 2'b00);
        rst = 1'b1;
        clear_model();
        @(negedge clk);
        check(beat_drive === 1'b0, "R7", "drive during reset", {17'd0, beat_drive}, '0);
        @(negedge clk);
        check(beat_drive === 1'b0, "R7", "drive during reset", {17'd0, beat_drive}, '0);
        rst = 1'b0;
        for (int s = 0; s < 10; s++) begin
            step(s, 0, 2'd0, '0, 2'b00, 2'b00);
            check(beat_drive === 1'b0, "R7", "dropped read beat", {17'd0, beat_drive}, '0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule